// File: doc/BRIEF.md
# Floating-point divide interlock controller

This block is the grouping-stage stall logic for a floating-point and graphics unit with one long-latency, non-pipelined divide/square-root engine. When the engine starts, the block loads the operation's latency into a countdown. It then holds any instruction in the current issue group that would collide with the operation in flight. Some collisions are structural: a second long operation, or a multiplier dispatch while the divide needs the multiplier for final rounding. Some are ordering collisions: a first-arriving add or multiply op in the last cycle before a dependent instruction is released. The rest are register collisions with the divide's destination. It also splits a conditional move away from a compare in the same group when both use the same condition-code field.

Each issue slot presents a class code, destination and source register numbers, a condition-code selector and a first-arrival flag. The block returns one hold bit per slot. Grouping stays in order, so a held slot holds every later slot. A load-use stall that arrives late in the divide freezes the countdown. The block pulses `div_done` when the result is complete.

Top module: `fp_div_interlock`

## Requirements
- R1: After reset every `slot_hold` bit and `div_done` are 0, and no divide is in flight.
- R2: A `div_start` sampled at clock edge k with latency L makes the divide busy for the L cycles after edge k. `div_done` is 1 for exactly the one cycle that follows the last busy cycle.
- R3: While `load_stall` is 1 and the cycles remaining are 4 or 3, the countdown does not advance, so completion slips by one cycle per stalled cycle. A stall at any other remaining count has no effect on timing.
- R4: A valid slot of class SERIAL (code 3: divide, square root, block load/store, status-register load/store) is held in every busy cycle and is not held once the divide is idle.
- R5: A valid slot of class FGM (code 2, multiply-class) is held in the cycle where exactly 3 cycles remain, and is not held for this reason at any other count.
- R6: While busy, a valid slot is held if its destination or either source matches the divide's destination. For a single-precision divide (`div_single`=1) register bit 0 is ignored, so the whole even/odd pair is locked. For a double-precision divide the match is exact. The lock is gone in the cycle `div_done` is 1.
- R7: A valid slot of class FGA (code 1) or FGM (code 2) with `slot_first`=1 is held when 1 cycle remains, if some slot showed an R6 register hazard earlier during the same divide. Without such a hazard, or with `slot_first`=0, it is not held for this reason.
- R8: A valid slot of class FMOVCC (code 5) is held when an earlier valid slot in the same group is class FCMP (code 4) with the same `slot_cc` value. With different values it is not held. This check applies whether or not a divide is busy.
- R9: Slot 0 is the oldest. A held slot forces a hold on every later valid slot, and an invalid slot never reports a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_start | input | 1 | One-cycle pulse: divide/square root begins |
| div_lat | input | LAT_W | Latency of the starting operation, at least 1 |
| div_rd | input | REG_W | Destination register of the starting operation |
| div_single | input | 1 | Starting operation has a single-precision result |
| load_stall | input | 1 | Load-use stall in this cycle |
| slot_vld | input | GROUP | Slot holds an instruction |
| slot_first | input | GROUP | Instruction reaches the grouping stage this cycle for the first time |
| slot_cls | input | GROUP x 3 | Class code per slot (0 none, 1 FGA, 2 FGM, 3 SERIAL, 4 FCMP, 5 FMOVCC, 6 other) |
| slot_rd | input | GROUP x REG_W | Destination register per slot |
| slot_rs1 | input | GROUP x REG_W | First source register per slot |
| slot_rs2 | input | GROUP x REG_W | Second source register per slot |
| slot_cc | input | GROUP x CC_W | Condition-code field selector per slot |
| slot_hold | output | GROUP | Hold this slot at the grouping stage |
| div_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `div_start` is a single-cycle pulse raised only while no divide is in flight, and that its latency is at least 1. Upstream logic guarantees this because it holds every SERIAL instruction while busy. The bench raises a start only after the previous `div_done`, with latencies of 3 to 8, and applies slot contents only while the start pulse is low. That keeps each expected hold tied to a known remaining count.

// File: rtl/fdi_pkg.sv
package fdi_pkg;
  typedef enum logic [2:0] {
    CL_NONE   = 3'd0,
    CL_FGA    = 3'd1,
    CL_FGM    = 3'd2,
    CL_SERIAL = 3'd3,
    CL_FCMP   = 3'd4,
    CL_FMOVCC = 3'd5,
    CL_OTHER  = 3'd6
  } icls_e;
  localparam int CLS_W = 3;
endpackage

// File: rtl/fdi_countdown.sv
module fdi_countdown #(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] lat,
  input  logic             load_stall,
  output logic [LAT_W-1:0] remain,
  output logic             busy,
  output logic             done
);
  logic freeze;

  assign busy   = (remain != '0);
  // late load stalls push completion back (R3)
  assign freeze = load_stall && (remain == LAT_W'(3) || remain == LAT_W'(4));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remain <= lat;
      end else if (busy && !freeze) begin
        remain <= remain - 1'b1;
        if (remain == LAT_W'(1)) done <= 1'b1;
      end
    end
  end

  assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !load_stall) |=> remain == $past(remain) - 1'b1);
  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && load_stall && (remain == LAT_W'(3) || remain == LAT_W'(4))) |=> $stable(remain));
  assert_done_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!busy && lat != '0));
endmodule

// File: rtl/fdi_lock.sv
module fdi_lock #(
  parameter int REG_W = 5,
  parameter int GROUP = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        capture,
  input  logic [REG_W-1:0]            cap_rd,
  input  logic                        cap_single,
  input  logic                        busy,
  input  logic [GROUP-1:0][REG_W-1:0] rd,
  input  logic [GROUP-1:0][REG_W-1:0] rs1,
  input  logic [GROUP-1:0][REG_W-1:0] rs2,
  output logic [GROUP-1:0]            hit
);
  logic [REG_W-1:0] lock_rd;
  logic             lock_pair;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_rd   <= '0;
      lock_pair <= 1'b0;
    end else if (capture) begin
      lock_rd   <= cap_rd;
      lock_pair <= cap_single;
    end
  end

  function automatic logic reg_match(input logic [REG_W-1:0] r,
                                     input logic [REG_W-1:0] l,
                                     input logic pair);
    if (pair) reg_match = (r[REG_W-1:1] == l[REG_W-1:1]);
    else      reg_match = (r == l);
  endfunction

  for (genvar i = 0; i < GROUP; i++) begin : g_slot
    assign hit[i] = busy && (reg_match(rd[i],  lock_rd, lock_pair) ||
                             reg_match(rs1[i], lock_rd, lock_pair) ||
                             reg_match(rs2[i], lock_rd, lock_pair));
  end

  assert_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && cap_single) |=> (lock_rd[REG_W-1:1] == $past(cap_rd[REG_W-1:1]) && lock_pair));
endmodule

// File: rtl/fdi_group_hold.sv
module fdi_group_hold
  import fdi_pkg::*;
#(
  parameter int GROUP = 2,
  parameter int CC_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [GROUP-1:0]            vld,
  input  logic [GROUP-1:0]            first,
  input  logic [GROUP-1:0][CLS_W-1:0] cls,
  input  logic [GROUP-1:0][CC_W-1:0]  cc,
  input  logic [GROUP-1:0]            hit,
  input  logic                        busy,
  input  logic                        near3,
  input  logic                        near1,
  input  logic                        dep_any,
  output logic [GROUP-1:0]            hold
);
  logic [GROUP-1:0] own;
  logic [GROUP-1:0] blk;
  logic [GROUP-1:0] cc_haz;

  always_comb begin
    for (int i = 0; i < GROUP; i++) begin
      cc_haz[i] = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (vld[j] && icls_e'(cls[j]) == CL_FCMP && icls_e'(cls[i]) == CL_FMOVCC &&
            cc[j] == cc[i])
          cc_haz[i] = 1'b1;
      end
      own[i] = vld[i] && (
                 hit[i] ||
                 (busy && icls_e'(cls[i]) == CL_SERIAL) ||
                 (near3 && icls_e'(cls[i]) == CL_FGM) ||
                 (near1 && dep_any && first[i] &&
                  (icls_e'(cls[i]) == CL_FGA || icls_e'(cls[i]) == CL_FGM)) ||
                 cc_haz[i]);
    end
  end

  always_comb begin
    blk[0] = 1'b0;
    for (int i = 1; i < GROUP; i++) blk[i] = blk[i-1] | own[i-1];
  end

  assign hold = vld & (own | blk);

  for (genvar i = 0; i < GROUP; i++) begin : g_chk
    assert_serial_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && vld[i] && icls_e'(cls[i]) == CL_SERIAL) |-> hold[i]);
    assert_mul_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (near3 && vld[i] && icls_e'(cls[i]) == CL_FGM) |-> hold[i]);
    assert_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !vld[i] |-> !hold[i]);
    if (i > 0) begin : g_ord
      assert_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold[i-1] && vld[i]) |-> hold[i]);
    end
  end
endmodule

// File: rtl/fp_div_interlock.sv
module fp_div_interlock
  import fdi_pkg::*;
#(
  parameter int GROUP = 2,
  parameter int LAT_W = 6,
  parameter int REG_W = 5,
  parameter int CC_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        div_start,
  input  logic [LAT_W-1:0]            div_lat,
  input  logic [REG_W-1:0]            div_rd,
  input  logic                        div_single,
  input  logic                        load_stall,
  input  logic [GROUP-1:0]            slot_vld,
  input  logic [GROUP-1:0]            slot_first,
  input  logic [GROUP-1:0][CLS_W-1:0] slot_cls,
  input  logic [GROUP-1:0][REG_W-1:0] slot_rd,
  input  logic [GROUP-1:0][REG_W-1:0] slot_rs1,
  input  logic [GROUP-1:0][REG_W-1:0] slot_rs2,
  input  logic [GROUP-1:0][CC_W-1:0]  slot_cc,
  output logic [GROUP-1:0]            slot_hold,
  output logic                        div_done
);
  logic [LAT_W-1:0] remain;
  logic             busy;
  logic [GROUP-1:0] hit;
  logic             dep_q;
  logic             dep_any;

  fdi_countdown #(.LAT_W(LAT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(div_start), .lat(div_lat),
    .load_stall(load_stall), .remain(remain), .busy(busy), .done(div_done)
  );

  fdi_lock #(.REG_W(REG_W), .GROUP(GROUP)) u_lock (
    .clk(clk), .rst_n(rst_n), .capture(div_start), .cap_rd(div_rd),
    .cap_single(div_single), .busy(busy), .rd(slot_rd), .rs1(slot_rs1),
    .rs2(slot_rs2), .hit(hit)
  );

  // a dependent instruction has waited on this divide (R7)
  always_ff @(posedge clk) begin
    if (!rst_n)                     dep_q <= 1'b0;
    else if (div_start || !busy)    dep_q <= 1'b0;
    else if (|(hit & slot_vld))     dep_q <= 1'b1;
  end
  assign dep_any = dep_q | (|(hit & slot_vld));

  fdi_group_hold #(.GROUP(GROUP), .CC_W(CC_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .vld(slot_vld), .first(slot_first),
    .cls(slot_cls), .cc(slot_cc), .hit(hit), .busy(busy),
    .near3(remain == LAT_W'(3)), .near1(remain == LAT_W'(1)),
    .dep_any(dep_any), .hold(slot_hold)
  );

  assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_start) && slot_vld[0] && slot_rd[0] == $past(div_rd)) |-> slot_hold[0]);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> !busy);
endmodule

// File: tb/sim_fp_div_interlock.sv
module sim_fp_div_interlock;
  import fdi_pkg::*;
  localparam int G = 2, LW = 6, RW = 5, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic div_start = 1'b0, div_single = 1'b0, load_stall = 1'b0;
  logic [LW-1:0] div_lat = '0;
  logic [RW-1:0] div_rd = '0;
  logic [G-1:0] slot_vld = '0, slot_first = '0, slot_hold;
  logic [G-1:0][2:0] slot_cls = '0;
  logic [G-1:0][RW-1:0] slot_rd = '0, slot_rs1 = '0, slot_rs2 = '0;
  logic [G-1:0][CW-1:0] slot_cc = '0;
  logic div_done;

  int checks = 0, errors = 0;

  typedef struct { logic [G-1:0] hold; logic done; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  fp_div_interlock #(.GROUP(G), .LAT_W(LW), .REG_W(RW), .CC_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .div_start(div_start), .div_lat(div_lat),
    .div_rd(div_rd), .div_single(div_single), .load_stall(load_stall),
    .slot_vld(slot_vld), .slot_first(slot_first), .slot_cls(slot_cls),
    .slot_rd(slot_rd), .slot_rs1(slot_rs1), .slot_rs2(slot_rs2),
    .slot_cc(slot_cc), .slot_hold(slot_hold), .div_done(div_done)
  );

  // monitor: compares results against the scoreboard queue
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (slot_hold !== e.hold) begin
        errors++;
        $display("FAIL %s hold actual=%b expected=%b", e.tag, slot_hold, e.hold);
      end
      checks++;
      if (div_done !== e.done) begin
        errors++;
        $display("FAIL %s done actual=%b expected=%b", e.tag, div_done, e.done);
      end
    end
  end

  task automatic clr();
    div_start = 1'b0; load_stall = 1'b0;
    slot_vld = '0; slot_first = '0; slot_cls = '0;
    slot_rd = '0; slot_rs1 = '0; slot_rs2 = '0; slot_cc = '0;
  endtask

  task automatic put(int s, icls_e c, int rd, int r1, int r2, int cc, bit fst);
    slot_vld[s] = 1'b1; slot_cls[s] = c; slot_first[s] = fst;
    slot_rd[s] = RW'(rd); slot_rs1[s] = RW'(r1); slot_rs2[s] = RW'(r2);
    slot_cc[s] = CW'(cc);
  endtask

  task automatic cyc(logic [G-1:0] eh, logic ed, string tag);
    exp_t e;
    e.hold = eh; e.done = ed; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic start_div(int lat, int rd, bit single);
    @(negedge clk); clr();
    div_start = 1'b1; div_lat = LW'(lat); div_rd = RW'(rd); div_single = single;
    cyc(2'b00, 1'b0, "R2 start");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); clr(); rst_n = 1'b1;
    cyc(2'b00, 1'b0, "R1 reset state");
    // R8 idle: same cc compare and move split
    @(negedge clk); clr(); put(0, CL_FCMP, 1, 2, 3, 0, 1); put(1, CL_FMOVCC, 4, 5, 12, 0, 1);
    cyc(2'b10, 1'b0, "R8 idle same cc");
    @(negedge clk); clr(); put(0, CL_SERIAL, 1, 2, 3, 0, 1);
    cyc(2'b00, 1'b0, "R4 idle serial free");

    // run 1: single precision, latency 8, dest 6 locks pair 6/7
    start_div(8, 6, 1'b1);
    @(negedge clk); clr(); put(0, CL_SERIAL, 20, 21, 22, 0, 1); put(1, CL_FGA, 10, 11, 12, 0, 1);
    cyc(2'b11, 1'b0, "R4 serial busy, R9 order");       // remain 8
    @(negedge clk); clr(); put(0, CL_FGA, 10, 7, 11, 0, 1);
    cyc(2'b01, 1'b0, "R6 single pair source");           // 7
    @(negedge clk); clr(); put(0, CL_FGA, 8, 9, 10, 0, 1); put(1, CL_FGM, 12, 13, 14, 0, 1);
    cyc(2'b00, 1'b0, "R5 FGM not at 6");                 // 6
    @(negedge clk); clr(); put(0, CL_FCMP, 0, 8, 9, 1, 1); put(1, CL_FMOVCC, 10, 11, 12, 1, 1);
    cyc(2'b10, 1'b0, "R8 same cc busy");                 // 5
    @(negedge clk); clr(); put(0, CL_FCMP, 0, 8, 9, 1, 1); put(1, CL_FMOVCC, 10, 11, 12, 2, 1);
    cyc(2'b00, 1'b0, "R8 different cc");                 // 4
    @(negedge clk); clr(); put(0, CL_FGM, 10, 11, 12, 0, 1); put(1, CL_FGA, 13, 14, 15, 0, 1);
    cyc(2'b11, 1'b0, "R5 FGM at 3, R9 order");           // 3
    @(negedge clk); clr(); put(0, CL_FGM, 10, 11, 12, 0, 1);
    cyc(2'b00, 1'b0, "R5 FGM at 2");                     // 2
    @(negedge clk); clr(); put(0, CL_FGA, 10, 11, 12, 0, 1);
    cyc(2'b01, 1'b0, "R7 first FGA after dependent");    // 1
    @(negedge clk); clr(); put(0, CL_SERIAL, 20, 21, 22, 0, 1); put(1, CL_FGA, 10, 7, 12, 0, 1);
    cyc(2'b00, 1'b1, "R2 done, R4 R6 released");         // 0
    @(negedge clk); clr();
    cyc(2'b00, 1'b0, "R2 done single cycle");

    // run 2: double precision, latency 6, stalls
    start_div(6, 6, 1'b0);
    @(negedge clk); clr(); put(0, CL_FGA, 10, 7, 11, 0, 1); load_stall = 1'b1;
    cyc(2'b00, 1'b0, "R6 double exact, R3 stall at 6");  // 6
    @(negedge clk); clr(); put(0, CL_OTHER, 6, 11, 12, 0, 1); load_stall = 1'b1;
    cyc(2'b01, 1'b0, "R6 same destination");             // 5
    @(negedge clk); clr(); load_stall = 1'b1;
    cyc(2'b00, 1'b0, "R3 stall at 4");                   // 4 frozen
    @(negedge clk); clr(); load_stall = 1'b1;
    cyc(2'b00, 1'b0, "R3 stall at 4 again");             // 4 frozen
    @(negedge clk); clr(); put(0, CL_FGM, 10, 11, 12, 0, 1);
    cyc(2'b00, 1'b0, "R3 FGM at 4 after freeze");        // 4
    @(negedge clk); clr(); put(0, CL_FGM, 10, 11, 12, 0, 1);
    cyc(2'b01, 1'b0, "R3 R5 FGM at slipped 3");          // 3
    @(negedge clk); clr();
    cyc(2'b00, 1'b0, "R3 no early done");                // 2
    @(negedge clk); clr(); put(0, CL_FGA, 10, 11, 12, 0, 0);
    cyc(2'b00, 1'b0, "R7 not first arrival");            // 1
    @(negedge clk); clr();
    cyc(2'b00, 1'b1, "R3 delayed done");                 // 0

    // run 3: latency 3, no dependent
    start_div(3, 20, 1'b1);
    @(negedge clk); clr(); put(0, CL_FGM, 10, 11, 12, 0, 1);
    cyc(2'b01, 1'b0, "R5 FGM at 3 short");               // 3
    @(negedge clk); clr(); load_stall = 1'b1;
    cyc(2'b00, 1'b0, "R3 stall at 2 ignored");           // 2
    @(negedge clk); clr(); put(0, CL_FGA, 10, 11, 12, 0, 1);
    cyc(2'b00, 1'b0, "R7 no dependent");                 // 1
    @(negedge clk); clr(); put(0, CL_FGA, 10, 21, 12, 0, 1);
    cyc(2'b00, 1'b1, "R2 done on time, R6 cleared");     // 0
    @(negedge clk); clr();
    cyc(2'b00, 1'b0, "R2 after done");

    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule